// File: doc/BRIEF.md
# Segmented Memory Access Unit

This unit sits between a small 8-bit processor core and its byte-addressed memory. For every memory request from the core it chooses one of four 8-bit segment registers (code, data, extra, stack) from the request's access class and an extra-segment override bit. It forms the physical address by placing the chosen segment above the 8-bit offset, and it drives the memory read and write strobes. For stack accesses it also maintains the stack pointer.

A request is either a plain byte or a 16-bit value. A 16-bit value moves in a single memory operation across two consecutive byte addresses. The low byte goes to the lower address on byte lane 0, and the high byte goes to the next address on lane 1. The unit also enforces the rule that one instruction makes at most one data-side memory reference. A second reference within the same instruction, or a push whose operand is itself in memory, is refused and reported through an error flag.

The segment registers and the stack pointer are loaded from the register-file side through dedicated write ports. All memory-side outputs are registered and appear in the cycle after the request.

Top module: `segmem_unit`

## Requirements
- R1: A synchronous reset clears all four segment registers and the stack pointer to 0. After reset no strobe is active and `sp_out` reads 0.
- R2: An instruction fetch (class 0) always uses the code segment, whatever the value of `req_xseg`. It asserts `mem_rd` and never counts as the instruction's data reference.
- R3: A normal data access (class 1) uses the data segment, or the extra segment when `req_xseg` is 1. `req_we`=1 selects a write and `req_we`=0 selects a read.
- R4: A push (class 2) first lowers the stack pointer by 1 for a byte or by 2 for a 16-bit value. It then writes at the lowered pointer in the stack segment, or in the extra segment when `req_xseg` is 1.
- R5: A pop (class 3) reads at the current stack pointer in the stack segment, or in the extra segment when `req_xseg` is 1. It then raises the pointer by 1 for a byte or by 2 for a 16-bit value.
- R6: The physical address `mem_addr` is {segment, offset}. For a 16-bit access `mem_be`=11 and `mem_addr_hi` = `mem_addr`+1, wrapping over 16 bits. The low byte travels on `mem_wdata[7:0]`. For a byte access `mem_be`=01 and `mem_wdata[15:8]` is 0.
- R7: After a data, push or pop access has been accepted, a further such request before the next `insn_start` is refused. A refused request pulses `acc_err`, produces no strobe and leaves the stack pointer unchanged. A request that arrives together with `insn_start` belongs to the new instruction.
- R8: A push with `req_mem_src`=1, meaning a memory operand, is refused in the same way as in R7.
- R9: `seg_we` loads `seg_wdata` into the segment register selected by `seg_sel`, with 0=code, 1=data, 2=extra and 3=stack. `sp_we` loads `sp_wdata` into the stack pointer and takes priority over a push or pop adjustment in the same cycle.
- R10: All outputs are registered. Strobes, `mem_be` and `acc_err` are valid in the cycle after the request and last exactly one cycle. `mem_rd` and `mem_wr` are never both 1.
- R11: Stack pointer arithmetic wraps modulo 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| insn_start | input | 1 | Marks the first cycle of a new instruction |
| req_valid | input | 1 | Memory request present |
| req_class | input | 2 | 0 fetch, 1 data, 2 push, 3 pop |
| req_xseg | input | 1 | Extra-segment override |
| req_mem_src | input | 1 | Push operand comes from memory |
| req_we | input | 1 | Write for data-class requests |
| req_wide | input | 1 | 16-bit access |
| req_off | input | OFF_W | Offset (instruction pointer or data address) |
| req_wdata | input | 2*BYTE_W | Write value, low byte in lane 0 |
| seg_we | input | 1 | Segment register load |
| seg_sel | input | 2 | Segment register selected for load |
| seg_wdata | input | SEG_W | Segment load value |
| sp_we | input | 1 | Stack pointer load |
| sp_wdata | input | OFF_W | Stack pointer load value |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_be | output | 2 | Byte lane enables |
| mem_seg | output | SEG_W | Segment used |
| mem_off | output | OFF_W | Offset used |
| mem_addr | output | SEG_W+OFF_W | Address of lane 0 |
| mem_addr_hi | output | SEG_W+OFF_W | Address of lane 1 |
| mem_wdata | output | 2*BYTE_W | Write data |
| acc_err | output | 1 | Refused request pulse |
| sp_out | output | OFF_W | Current stack pointer |

## Verification
The assertions assume that `insn_start` and any request are presented only while `rst` is low. They also assume that `req_class` and the other request fields hold defined values whenever `req_valid` is 1. The stack-pointer properties take for granted that a push and a pop are never requested in the same cycle, which the single-class encoding guarantees. The stimulus drives all inputs on the falling edge, issues at most one request per cycle, and applies segment or pointer loads only in cycles where the resulting register value is not needed by that same request. The one exception is a deliberate collision between a stack-pointer load and a push.

// File: rtl/segmem_pkg.sv
package segmem_pkg;
   localparam int NUM_SEGS = 4;
   localparam int SEL_W    = 2;

   typedef enum logic [1:0] {
      ACC_FETCH = 2'd0,
      ACC_DATA  = 2'd1,
      ACC_PUSH  = 2'd2,
      ACC_POP   = 2'd3
   } acc_class_e;

   typedef enum logic [1:0] {
      SEG_CODE  = 2'd0,
      SEG_DATA  = 2'd1,
      SEG_EXTRA = 2'd2,
      SEG_STACK = 2'd3
   } seg_id_e;
endpackage

// File: rtl/segmem_seg_bank.sv
module segmem_seg_bank
   import segmem_pkg::*;
#(
   parameter int SEG_W = 8
) (
   input  logic                             clk,
   input  logic                             rst,
   input  logic                             wr_en,
   input  logic [SEL_W-1:0]                 wr_sel,
   input  logic [SEG_W-1:0]                 wr_val,
   output logic [NUM_SEGS-1:0][SEG_W-1:0]   seg_q
);
   genvar g;
   generate
      for (g = 0; g < NUM_SEGS; g++) begin : g_seg
         logic [SEG_W-1:0] val_r;
         always_ff @(posedge clk) begin
            if (rst)
               val_r <= '0;
            else if (wr_en && (wr_sel == SEL_W'(g)))
               val_r <= wr_val;
         end
         assign seg_q[g] = val_r;
      end
   endgenerate

   // R9: a load lands in the selected register on the next cycle
   a_r9_seg_load : assert property (@(posedge clk) disable iff (rst)
      wr_en |=> seg_q[$past(wr_sel)] == $past(wr_val));
endmodule

// File: rtl/segmem_seg_pick.sv
module segmem_seg_pick
   import segmem_pkg::*;
#(
   parameter int SEG_W = 8
) (
   input  logic [1:0]                       cls,
   input  logic                             xseg,
   input  logic [NUM_SEGS-1:0][SEG_W-1:0]   seg_q,
   output seg_id_e                          seg_id,
   output logic [SEG_W-1:0]                 seg_val
);
   always_comb begin
      unique case (acc_class_e'(cls))
         ACC_FETCH: seg_id = SEG_CODE;
         ACC_DATA:  seg_id = xseg ? SEG_EXTRA : SEG_DATA;
         default:   seg_id = xseg ? SEG_EXTRA : SEG_STACK;
      endcase
   end

   assign seg_val = seg_q[seg_id];

   // R2: fetch never reaches the override
   always_comb begin
      if (cls == ACC_FETCH)
         a_r2_fetch_code : assert (seg_id == SEG_CODE);
   end
endmodule

// File: rtl/segmem_sp_unit.sv
module segmem_sp_unit #(
   parameter int OFF_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             push_go,
   input  logic             pop_go,
   input  logic             wide,
   input  logic             ld_en,
   input  logic [OFF_W-1:0] ld_val,
   output logic [OFF_W-1:0] sp_q,
   output logic [OFF_W-1:0] sp_dec
);
   logic [OFF_W-1:0] step;
   logic [OFF_W-1:0] sp_nx;

   assign step   = wide ? OFF_W'(2) : OFF_W'(1);
   assign sp_dec = sp_q - step;

   always_comb begin
      sp_nx = sp_q;
      if (ld_en)        sp_nx = ld_val;
      else if (push_go) sp_nx = sp_dec;
      else if (pop_go)  sp_nx = sp_q + step;
   end

   always_ff @(posedge clk) begin
      if (rst) sp_q <= '0;
      else     sp_q <= sp_nx;
   end

   // R4: push lowers the pointer by the access size
   a_r4_push_lowers : assert property (@(posedge clk) disable iff (rst)
      (push_go && !ld_en) |=> sp_q == $past(sp_q) - ($past(wide) ? OFF_W'(2) : OFF_W'(1)));
   // R5: pop raises the pointer by the access size
   a_r5_pop_raises : assert property (@(posedge clk) disable iff (rst)
      (pop_go && !ld_en) |=> sp_q == $past(sp_q) + ($past(wide) ? OFF_W'(2) : OFF_W'(1)));
   // R9: load wins
   a_r9_sp_load : assert property (@(posedge clk) disable iff (rst)
      ld_en |=> sp_q == $past(ld_val));
   // R7: untouched without load or stack access
   a_r7_sp_hold : assert property (@(posedge clk) disable iff (rst)
      (!ld_en && !push_go && !pop_go) |=> $stable(sp_q));
endmodule

// File: rtl/segmem_ref_guard.sv
module segmem_ref_guard
   import segmem_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       insn_start,
   input  logic       req_valid,
   input  logic [1:0] cls,
   input  logic       mem_src,
   output logic       accept,
   output logic       illegal
);
   logic used_r;
   logic counted;
   logic second;
   logic nested;

   assign counted = req_valid && (cls != ACC_FETCH);
   assign second  = used_r && !insn_start;
   assign nested  = (cls == ACC_PUSH) && mem_src;
   assign illegal = counted && (second || nested);
   assign accept  = req_valid && !illegal;

   always_ff @(posedge clk) begin
      if (rst)             used_r <= 1'b0;
      else if (insn_start) used_r <= counted && accept;
      else if (counted && accept) used_r <= 1'b1;
   end

   // R7: an accepted reference closes the instruction for further ones
   a_r7_closes : assert property (@(posedge clk) disable iff (rst)
      (counted && accept) |=> used_r);
   // R2: a fetch alone never closes a fresh instruction
   a_r2_fetch_free : assert property (@(posedge clk) disable iff (rst)
      (insn_start && !counted) |=> !used_r);
endmodule

// File: rtl/segmem_unit.sv
module segmem_unit
   import segmem_pkg::*;
#(
   parameter int SEG_W  = 8,
   parameter int OFF_W  = 8,
   parameter int BYTE_W = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      insn_start,
   input  logic                      req_valid,
   input  logic [1:0]                req_class,
   input  logic                      req_xseg,
   input  logic                      req_mem_src,
   input  logic                      req_we,
   input  logic                      req_wide,
   input  logic [OFF_W-1:0]          req_off,
   input  logic [2*BYTE_W-1:0]       req_wdata,
   input  logic                      seg_we,
   input  logic [1:0]                seg_sel,
   input  logic [SEG_W-1:0]          seg_wdata,
   input  logic                      sp_we,
   input  logic [OFF_W-1:0]          sp_wdata,
   output logic                      mem_rd,
   output logic                      mem_wr,
   output logic [1:0]                mem_be,
   output logic [SEG_W-1:0]          mem_seg,
   output logic [OFF_W-1:0]          mem_off,
   output logic [SEG_W+OFF_W-1:0]    mem_addr,
   output logic [SEG_W+OFF_W-1:0]    mem_addr_hi,
   output logic [2*BYTE_W-1:0]       mem_wdata,
   output logic                      acc_err,
   output logic [OFF_W-1:0]          sp_out
);
   localparam int ADDR_W = SEG_W + OFF_W;
   localparam int DATA_W = 2 * BYTE_W;

   generate
      if (SEG_W < 1) begin : g_bad_seg
         $error("segmem_unit: SEG_W must be at least 1");
      end
      if (OFF_W < 2) begin : g_bad_off
         $error("segmem_unit: OFF_W must be at least 2 for 16-bit stack steps");
      end
      if (BYTE_W < 1) begin : g_bad_byte
         $error("segmem_unit: BYTE_W must be at least 1");
      end
   endgenerate

   logic [NUM_SEGS-1:0][SEG_W-1:0] seg_q;
   seg_id_e          seg_id;
   logic [SEG_W-1:0] seg_val;
   logic             accept, illegal;
   logic             is_push, is_pop, is_data;
   logic             push_go, pop_go;
   logic [OFF_W-1:0] sp_q, sp_dec;
   logic [OFF_W-1:0] off_sel;
   logic             do_wr, do_rd;
   logic [DATA_W-1:0] wdata_sel;

   segmem_seg_bank #(.SEG_W(SEG_W)) u_bank (
      .clk(clk), .rst(rst), .wr_en(seg_we), .wr_sel(seg_sel),
      .wr_val(seg_wdata), .seg_q(seg_q));

   segmem_seg_pick #(.SEG_W(SEG_W)) u_pick (
      .cls(req_class), .xseg(req_xseg), .seg_q(seg_q),
      .seg_id(seg_id), .seg_val(seg_val));

   segmem_ref_guard u_guard (
      .clk(clk), .rst(rst), .insn_start(insn_start), .req_valid(req_valid),
      .cls(req_class), .mem_src(req_mem_src), .accept(accept), .illegal(illegal));

   assign is_push = (req_class == ACC_PUSH);
   assign is_pop  = (req_class == ACC_POP);
   assign is_data = (req_class == ACC_DATA);
   assign push_go = accept && is_push;
   assign pop_go  = accept && is_pop;

   segmem_sp_unit #(.OFF_W(OFF_W)) u_sp (
      .clk(clk), .rst(rst), .push_go(push_go), .pop_go(pop_go),
      .wide(req_wide), .ld_en(sp_we), .ld_val(sp_wdata),
      .sp_q(sp_q), .sp_dec(sp_dec));

   always_comb begin
      if (is_push)     off_sel = sp_dec;
      else if (is_pop) off_sel = sp_q;
      else             off_sel = req_off;
   end

   assign do_wr = accept && (is_push || (is_data && req_we));
   assign do_rd = accept && !(is_push || (is_data && req_we));

   always_comb begin
      if (!do_wr)        wdata_sel = '0;
      else if (req_wide) wdata_sel = req_wdata;
      else               wdata_sel = {{BYTE_W{1'b0}}, req_wdata[BYTE_W-1:0]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_rd      <= 1'b0;
         mem_wr      <= 1'b0;
         mem_be      <= 2'b00;
         mem_seg     <= '0;
         mem_off     <= '0;
         mem_addr    <= '0;
         mem_addr_hi <= '0;
         mem_wdata   <= '0;
         acc_err     <= 1'b0;
      end else begin
         mem_rd  <= do_rd;
         mem_wr  <= do_wr;
         mem_be  <= accept ? {req_wide, 1'b1} : 2'b00;
         acc_err <= illegal;
         if (accept) begin
            mem_seg     <= seg_val;
            mem_off     <= off_sel;
            mem_addr    <= {seg_val, off_sel};
            mem_addr_hi <= {seg_val, off_sel} + ADDR_W'(1);
            mem_wdata   <= wdata_sel;
         end
      end
   end

   assign sp_out = sp_q;

   // R10: never read and write together
   a_r10_rw_excl : assert property (@(posedge clk) disable iff (rst)
      !(mem_rd && mem_wr));
   // R10: a strobe lasts one cycle unless a new request arrived
   a_r10_one_shot : assert property (@(posedge clk) disable iff (rst)
      (!req_valid) |=> !mem_rd && !mem_wr && !acc_err);
   // R7: refused access is silent on the memory side
   a_r7_err_quiet : assert property (@(posedge clk) disable iff (rst)
      acc_err |-> !mem_rd && !mem_wr && mem_be == 2'b00);
   // R6: the upper lane is never enabled alone
   a_r6_lane_order : assert property (@(posedge clk) disable iff (rst)
      mem_be[1] |-> mem_be[0]);
   // R2: a fetch reads from the code segment
   a_r2_fetch_seg : assert property (@(posedge clk) disable iff (rst)
      (accept && req_class == ACC_FETCH) |=> mem_rd && mem_seg == $past(seg_q[SEG_CODE]));
   // R8: a push of a memory operand is refused
   a_r8_nested : assert property (@(posedge clk) disable iff (rst)
      (req_valid && is_push && req_mem_src) |=> acc_err && !mem_wr);
endmodule

// File: tb/segmem_unit_tb_top.sv
module segmem_unit_tb_top;
   logic clk = 1'b0;
   logic rst;
   logic insn_start, req_valid, req_xseg, req_mem_src, req_we, req_wide;
   logic [1:0]  req_class;
   logic [7:0]  req_off;
   logic [15:0] req_wdata;
   logic seg_we, sp_we;
   logic [1:0] seg_sel;
   logic [7:0] seg_wdata, sp_wdata;
   logic mem_rd, mem_wr, acc_err;
   logic [1:0] mem_be;
   logic [7:0] mem_seg, mem_off, sp_out;
   logic [15:0] mem_addr, mem_addr_hi, mem_wdata;

   always #5 clk = ~clk;

   segmem_unit dut_i (
      .clk(clk), .rst(rst), .insn_start(insn_start), .req_valid(req_valid),
      .req_class(req_class), .req_xseg(req_xseg), .req_mem_src(req_mem_src),
      .req_we(req_we), .req_wide(req_wide), .req_off(req_off), .req_wdata(req_wdata),
      .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
      .sp_we(sp_we), .sp_wdata(sp_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be), .mem_seg(mem_seg),
      .mem_off(mem_off), .mem_addr(mem_addr), .mem_addr_hi(mem_addr_hi),
      .mem_wdata(mem_wdata), .acc_err(acc_err), .sp_out(sp_out));

   typedef struct {
      logic rd, wr, err;
      logic [1:0] be;
      logic [15:0] addr, addr_hi, wdata;
      logic [7:0] sp;
      int due;
      string tag;
   } exp_t;

   exp_t exp_q[$];
   int n_cmp = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   logic [7:0] m_seg [4];
   logic [7:0] m_sp;
   bit m_used;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor
   always @(negedge clk) begin
      while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
         exp_t e;
         bit ok;
         e = exp_q.pop_front();
         ok = (mem_rd === e.rd) && (mem_wr === e.wr) && (acc_err === e.err) && (sp_out === e.sp);
         if (e.rd || e.wr)
            ok = ok && (mem_be === e.be) && (mem_addr === e.addr) &&
                 (!e.be[1] || mem_addr_hi === e.addr_hi) && (mem_seg === e.addr[15:8]) &&
                 (mem_off === e.addr[7:0]);
         if (e.wr) ok = ok && (mem_wdata === e.wdata);
         n_cmp++;
         if (!ok) begin
            n_bad++;
            $display("FAIL %s: got rd=%0b wr=%0b be=%b addr=%h hi=%h wd=%h err=%0b sp=%h; expected rd=%0b wr=%0b be=%b addr=%h hi=%h wd=%h err=%0b sp=%h",
               e.tag, mem_rd, mem_wr, mem_be, mem_addr, mem_addr_hi, mem_wdata, acc_err, sp_out,
               e.rd, e.wr, e.be, e.addr, e.addr_hi, e.wdata, e.err, e.sp);
         end
      end
   end

   task automatic clear_inputs();
      insn_start = 0; req_valid = 0; req_class = 0; req_xseg = 0; req_mem_src = 0;
      req_we = 0; req_wide = 0; req_off = 0; req_wdata = 0;
      seg_we = 0; seg_sel = 0; seg_wdata = 0; sp_we = 0; sp_wdata = 0;
   endtask

   task automatic push_idle(string tag);
      exp_t e;
      e.rd = 0; e.wr = 0; e.err = 0; e.be = 0; e.addr = 0; e.addr_hi = 0; e.wdata = 0;
      e.sp = m_sp; e.due = cyc + 1; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(string tag);
      @(negedge clk);
      clear_inputs();
      push_idle(tag);
   endtask

   task automatic load_seg(input logic [1:0] sel, input logic [7:0] v);
      @(negedge clk);
      clear_inputs();
      seg_we = 1; seg_sel = sel; seg_wdata = v;
      m_seg[sel] = v;
      push_idle("R9");
   endtask

   task automatic load_sp(input logic [7:0] v);
      @(negedge clk);
      clear_inputs();
      sp_we = 1; sp_wdata = v;
      m_sp = v;
      push_idle("R9");
   endtask

   task automatic req(input logic [1:0] cls, input bit xs, input bit msrc, input bit we,
                      input bit wide, input logic [7:0] off, input logic [15:0] wd,
                      input bit start, input bit spld, input logic [7:0] spv, input string tag);
      exp_t e;
      bit ill;
      logic [7:0] sg, o, st;
      @(negedge clk);
      clear_inputs();
      insn_start = start; req_valid = 1; req_class = cls; req_xseg = xs;
      req_mem_src = msrc; req_we = we; req_wide = wide; req_off = off; req_wdata = wd;
      sp_we = spld; sp_wdata = spv;
      if (start) m_used = 0;
      ill = (cls != 0) && (m_used || (cls == 2 && msrc));
      e.due = cyc + 1; e.tag = tag; e.be = 0; e.addr = 0; e.addr_hi = 0; e.wdata = 0;
      st = wide ? 8'd2 : 8'd1;
      if (ill) begin
         e.rd = 0; e.wr = 0; e.err = 1;
      end else begin
         e.err = 0;
         case (cls)
            2'd0: sg = m_seg[0];
            2'd1: sg = xs ? m_seg[2] : m_seg[1];
            default: sg = xs ? m_seg[2] : m_seg[3];
         endcase
         case (cls)
            2'd2: begin m_sp = m_sp - st; o = m_sp; end
            2'd3: begin o = m_sp; m_sp = m_sp + st; end
            default: o = off;
         endcase
         e.wr = (cls == 2) || (cls == 1 && we);
         e.rd = !e.wr;
         e.be = wide ? 2'b11 : 2'b01;
         e.addr = {sg, o};
         e.addr_hi = {sg, o} + 16'd1;
         e.wdata = wide ? wd : {8'h00, wd[7:0]};
         if (cls != 0) m_used = 1;
      end
      if (spld) m_sp = spv;
      e.sp = m_sp;
      exp_q.push_back(e);
   endtask

   initial begin
      clear_inputs();
      rst = 1;
      for (int i = 0; i < 4; i++) m_seg[i] = 0;
      m_sp = 0; m_used = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 0;
      push_idle("R1");
      // R1: fetch after reset uses zeroed code segment
      req(0, 0, 0, 0, 0, 8'h05, 0, 1, 0, 0, "R1");
      load_seg(0, 8'h12); load_seg(1, 8'h34); load_seg(2, 8'h56); load_seg(3, 8'h78);
      load_sp(8'h40);
      // R2: fetch ignores the override and does not count
      req(0, 0, 0, 0, 1, 8'h10, 0, 1, 0, 0, "R2");
      req(0, 1, 0, 0, 0, 8'h11, 0, 0, 0, 0, "R2");
      // R3: data read in data segment
      req(1, 0, 0, 0, 0, 8'h20, 0, 0, 0, 0, "R3");
      // R3/R6: wide write via extra segment
      req(1, 1, 0, 1, 1, 8'h21, 16'hABCD, 1, 0, 0, "R3_R6");
      // R7: second reference refused
      req(1, 0, 0, 1, 0, 8'h22, 16'h0011, 0, 0, 0, "R7");
      req(2, 0, 0, 0, 0, 8'h00, 16'h0022, 0, 0, 0, "R7");
      // R4: byte push
      req(2, 0, 0, 0, 0, 8'h00, 16'h5599, 1, 0, 0, "R4");
      // R4/R6: wide push to extra segment
      req(2, 1, 0, 0, 1, 8'h00, 16'h1357, 1, 0, 0, "R4_R6");
      // R5: wide then byte pop
      req(3, 0, 0, 0, 1, 8'h00, 0, 1, 0, 0, "R5");
      req(3, 1, 0, 0, 0, 8'h00, 0, 1, 0, 0, "R5");
      // R8: push of memory operand
      req(2, 0, 1, 0, 0, 8'h00, 16'h0077, 1, 0, 0, "R8");
      idle("R10");
      // R6: byte write zeroes upper lane
      req(1, 0, 0, 1, 0, 8'h30, 16'h1234, 1, 0, 0, "R6");
      idle("R10");
      // R11: wrap downward and upward
      load_sp(8'h00);
      req(2, 0, 0, 0, 1, 8'h00, 16'hBEEF, 1, 0, 0, "R11");
      load_sp(8'hFF);
      req(3, 0, 0, 0, 1, 8'h00, 0, 1, 0, 0, "R11_R6");
      // R9: load collides with push, load wins
      req(2, 0, 0, 0, 0, 8'h00, 16'h0042, 1, 1, 8'h80, "R9");
      idle("R10");
      // R7: start restores access
      req(1, 0, 0, 0, 0, 8'h44, 0, 1, 0, 0, "R7");
      idle("R10");
      repeat (3) @(negedge clk);
      if (!done) begin
         done = 1;
         if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R10: %0d expected items never compared (expected 0)", exp_q.size());
         end
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      wait (cyc > 5000);
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog: run hung, got cycle %0d expected completion", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule